// File: doc/BRIEF.md
# Parallel Bus Target Phase Sequencer

This block is the target end of an 8-bit parallel peripheral bus. It watches the free bus for a selection that carries its own ID. When it sees one, it claims the bus by raising BSY. From then on it owns the three phase lines: command/data (`cd_o`), direction (`io_o`) and message (`msg_o`). It paces every byte with a four-edge REQ/ACK interlock.

A transaction has a fixed order: command bytes from the initiator, then an optional run of read data bytes back to the initiator, then one status byte, then one completion message. After the last handshake the block lets go of every line and the bus is free again.

The first command byte holds an opcode and a count of further command bytes. The last of those further bytes sets how many data bytes a read returns. The data bytes themselves come from a local source, which is addressed by a byte index that the block presents.

Top module: `pbus_target_seq`

## Requirements
- R1: While reset is low, and after it is released with no selection, `bsy_o`, `req_o`, `cd_o`, `io_o`, `msg_o` and `bus_oe` are all 0 and `xfer_idx` is 0. Reset is asynchronous and active low.
- R2: From the free state the block raises `bsy_o` only when all four of these hold: `sel_i` is 1, `bsy_i` is 0, bit `own_id` of `bus_din` is 1, and exactly two bits of `bus_din` are 1. Any other selection pattern leaves `bsy_o` at 0.
- R3: After claiming the bus, the block waits for `sel_i` to fall. It then enters the command phase with `cd_o`=1, `io_o`=0 and `msg_o`=0. These lines are visible for at least one cycle before `req_o` rises.
- R4: `req_o` rises only while `ack_i` is 0. Once high, `req_o` stays high, with the phase lines and `bus_dout` held stable, until `ack_i` is seen high. `req_o` then falls, and no new `req_o` appears while `ack_i` remains high.
- R5: The first command byte is read as follows: bits [7:4] are the opcode and bits [3:0] are N, the number of further command bytes. Each further byte is taken by its own handshake. The value of the last of them is the data length L. If N is 0, L is 0.
- R6: When the opcode is 4'h1 (read) and L is nonzero, the data phase follows the command bytes. In this phase `cd_o`=0, `io_o`=1, `msg_o`=0 and `bus_oe`=1. Exactly L bytes are sent. Byte k (counting from 0) equals `xfer_byte` as sampled while `xfer_idx` equals k.
- R7: For any other opcode, or when L is 0, there is no data phase: the status phase follows the last command byte directly.
- R8: The status phase sends one byte 0x00 with `cd_o`=1, `io_o`=1 and `msg_o`=0.
- R9: The message phase sends one byte 0x00 with `cd_o`, `io_o` and `msg_o` all 1. After its ACK falls, the block returns to free and all driven lines go to 0.
- R10: Pulling `rst_n` low during any phase returns the block to free at once, with every driven line at 0. A later selection is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_id | input | 3 | ID this target answers to |
| sel_i | input | 1 | Select line from the initiator |
| bsy_i | input | 1 | Busy line as driven by other devices |
| ack_i | input | 1 | Acknowledge from the initiator |
| bus_din | input | 8 | Data lines as received |
| bsy_o | output | 1 | Busy driven by this target |
| req_o | output | 1 | Request strobe |
| cd_o | output | 1 | Command/data phase line |
| io_o | output | 1 | Direction line, 1 = toward initiator |
| msg_o | output | 1 | Message phase line |
| bus_dout | output | 8 | Byte driven onto the data lines |
| bus_oe | output | 1 | Enable for `bus_dout` |
| xfer_idx | output | 8 | Index of the read byte being fetched |
| xfer_byte | input | 8 | Read data byte for `xfer_idx` |

## Verification
The properties assume that the initiator follows the interlock. It raises ACK only while REQ is high, and it lowers ACK only after REQ has fallen. They also assume that `xfer_byte` is a function of `xfer_idx` alone.

The bench plays an initiator that reacts only to edges it has sampled. It keeps ACK high for extra cycles after REQ drops. It changes `own_id` and the data seed only while the bus is free. Random transactions vary the opcode, the extra-byte count, the length and both IDs. Directed cases add the longest read, selections that must be refused, and a reset in mid-command.

// File: rtl/pbus_target_seq.sv
module pbus_target_seq #(
  parameter int DW = 8,
  parameter int OPW = 4,
  parameter logic [OPW-1:0] OP_READ = 4'h1,
  parameter logic [DW-1:0] STAT_GOOD = '0,
  parameter logic [DW-1:0] MSG_DONE = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [$clog2(DW)-1:0] own_id,
  input  logic                  sel_i,
  input  logic                  bsy_i,
  input  logic                  ack_i,
  input  logic [DW-1:0]         bus_din,
  output logic                  bsy_o,
  output logic                  req_o,
  output logic                  cd_o,
  output logic                  io_o,
  output logic                  msg_o,
  output logic [DW-1:0]         bus_dout,
  output logic                  bus_oe,
  output logic [DW-1:0]         xfer_idx,
  input  logic [DW-1:0]         xfer_byte
);
  localparam int NW = DW - OPW;

  typedef enum logic [2:0] {S_FREE, S_SEL, S_SETUP, S_REQ, S_REL} st_t;
  typedef enum logic [1:0] {P_CMD, P_DATA, P_STAT, P_MSG} ph_t;

  st_t st;
  ph_t ph;
  logic           first;
  logic [OPW-1:0] op;
  logic [NW-1:0]  left;
  logic [DW-1:0]  len, idx, dout;
  logic           hs, sel_hit;
  logic [DW-1:0]  next_out;

  assign sel_hit = sel_i && !bsy_i && bus_din[own_id] && ($countones(bus_din) == 2);
  assign hs      = (st == S_SETUP) || (st == S_REQ) || (st == S_REL);

  assign bsy_o    = st != S_FREE;
  assign req_o    = st == S_REQ;
  assign cd_o     = hs && ph != P_DATA;
  assign io_o     = hs && ph != P_CMD;
  assign msg_o    = hs && ph == P_MSG;
  assign bus_oe   = io_o;
  assign bus_dout = dout;
  assign xfer_idx = idx;

  always_comb begin
    case (ph)
      P_DATA:  next_out = xfer_byte;
      P_STAT:  next_out = STAT_GOOD;
      P_MSG:   next_out = MSG_DONE;
      default: next_out = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FREE;
      ph <= P_CMD;
      first <= 1'b0;
      op <= '0;
      left <= '0;
      len <= '0;
      idx <= '0;
      dout <= '0;
    end else begin
      case (st)
        S_FREE: if (sel_hit) st <= S_SEL;
        S_SEL: if (!sel_i) begin
          st <= S_SETUP;
          ph <= P_CMD;
          first <= 1'b1;
          len <= '0;
          idx <= '0;
        end
        S_SETUP: if (!ack_i) begin
          st <= S_REQ;
          dout <= next_out;
        end
        S_REQ: if (ack_i) begin
          st <= S_REL;
          if (ph == P_CMD) begin
            if (first) begin
              first <= 1'b0;
              op <= bus_din[DW-1 -: OPW];
              left <= bus_din[NW-1:0];
            end else begin
              left <= left - 1'b1;
              len <= bus_din;
            end
          end
          if (ph == P_DATA) idx <= idx + 1'b1;
        end
        S_REL: if (!ack_i) begin
          case (ph)
            P_CMD: begin
              st <= S_SETUP;
              if (left == '0) ph <= (op == OP_READ && len != '0) ? P_DATA : P_STAT;
            end
            P_DATA: begin
              st <= S_SETUP;
              if (idx == len) ph <= P_STAT;
            end
            P_STAT: begin
              st <= S_SETUP;
              ph <= P_MSG;
            end
            default: begin
              st <= S_FREE;
              ph <= P_CMD;
            end
          endcase
        end
        default: st <= S_FREE;
      endcase
    end
  end
endmodule

// File: rtl/pbus_target_seq_sva.sv
module pbus_target_seq_sva #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_i,
  input logic          bsy_o,
  input logic          req_o,
  input logic          cd_o,
  input logic          io_o,
  input logic          msg_o,
  input logic          bus_oe,
  input logic [DW-1:0] bus_dout
);
  // R4: a new request never starts while the previous ACK is still high
  p_req_after_ack_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !ack_i);

  // R4: a request is held until the acknowledge arrives
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o);

  // R4: phase lines and data stay put while a byte is offered
  p_lines_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> $stable({cd_o, io_o, msg_o, bus_dout}));

  // R9: nothing is driven while the bus is not claimed
  p_free_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy_o |-> !(req_o || cd_o || io_o || msg_o || bus_oe));

  // R9: the message phase keeps command/data and direction asserted
  p_msg_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_o |-> (cd_o && io_o));

  // R6: data is driven only toward the initiator while the bus is held
  p_drive_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (io_o && bsy_o));
endmodule

bind pbus_target_seq pbus_target_seq_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .bsy_o(bsy_o), .req_o(req_o),
  .cd_o(cd_o), .io_o(io_o), .msg_o(msg_o), .bus_oe(bus_oe), .bus_dout(bus_dout)
);

// File: tb/pbus_target_seq_tb.sv
module pbus_target_seq_tb;
  logic clk = 1'b0;
  logic rst_n, sel_i, bsy_i, ack_i;
  logic [2:0] own_id;
  logic [7:0] bus_din, bus_dout, xfer_idx, xfer_byte, salt;
  logic bsy_o, req_o, cd_o, io_o, msg_o, bus_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [7:0] k, input logic [7:0] s);
    return (k * 8'd37 + 8'd11) ^ s;
  endfunction

  assign xfer_byte = pat(xfer_idx, salt);

  pbus_target_seq u_dut (
    .clk(clk), .rst_n(rst_n), .own_id(own_id), .sel_i(sel_i), .bsy_i(bsy_i),
    .ack_i(ack_i), .bus_din(bus_din), .bsy_o(bsy_o), .req_o(req_o), .cd_o(cd_o),
    .io_o(io_o), .msg_o(msg_o), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .xfer_idx(xfer_idx), .xfer_byte(xfer_byte)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [5:0] lines();
    return {bsy_o, req_o, cd_o, io_o, msg_o, bus_oe};
  endfunction

  task automatic xfer(input logic ecd, input logic eio, input logic emsg,
                      input logic [7:0] cb, input logic [7:0] eb, input string rq);
    int n = 0;
    while (!req_o && n < 200) begin @(negedge clk); n++; end
    chk(req_o, {rq, " request seen"}, req_o, 1);
    if (!req_o) return;
    chk({cd_o, io_o, msg_o} == {ecd, eio, emsg}, {rq, " phase lines"}, {cd_o, io_o, msg_o}, {ecd, eio, emsg});
    if (eio) chk(bus_oe && bus_dout == eb, {rq, " byte to initiator"}, {bus_oe, bus_dout}, {1'b1, eb});
    else begin
      chk(!bus_oe, {rq, " bus released in command"}, bus_oe, 0);
      bus_din = cb;
    end
    @(negedge clk);
    chk(req_o, "R4 request held before ack", req_o, 1);
    ack_i = 1'b1;
    n = 0;
    while (req_o && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk(!req_o, "R4 no request while ack high", req_o, 0);
    ack_i = 1'b0;
    bus_din = '0;
    @(negedge clk);
  endtask

  task automatic select(input logic [7:0] mask, output bit ok);
    int n = 0;
    @(negedge clk);
    bus_din = mask; sel_i = 1'b1; bsy_i = 1'b0;
    while (!bsy_o && n < 20) begin @(negedge clk); n++; end
    ok = bsy_o;
    bus_din = '0; sel_i = 1'b0;
  endtask

  task automatic refuse(input logic [7:0] mask, input logic busy, input string rq);
    @(negedge clk);
    bus_din = mask; sel_i = 1'b1; bsy_i = busy;
    repeat (5) @(negedge clk);
    chk(!bsy_o, rq, bsy_o, 0);
    bus_din = '0; sel_i = 1'b0; bsy_i = 1'b0;
    @(negedge clk);
    chk(!bsy_o, rq, bsy_o, 0);
  endtask

  task automatic txn(input logic [3:0] op, input logic [3:0] nx, input logic [7:0] len, input logic [2:0] ini);
    bit ok;
    int n = 0;
    logic [7:0] eff;
    select((8'd1 << own_id) | (8'd1 << ini), ok);
    chk(ok, "R2 valid selection claimed", ok, 1);
    if (!ok) return;
    while (!cd_o && n < 20) begin @(negedge clk); n++; end
    chk(cd_o && !io_o && !msg_o && !req_o, "R3 command lines before request",
        {cd_o, io_o, msg_o, req_o}, 4'b1000);
    xfer(1, 0, 0, {op, nx}, 0, "R5 first command byte");
    for (int i = 0; i < nx; i++)
      xfer(1, 0, 0, (i == nx - 1) ? len : 8'($urandom), 0, "R5 extra command byte");
    eff = (nx == 0) ? 8'd0 : len;
    if (op == 4'h1 && eff != 0) begin
      for (int k = 0; k < eff; k++) xfer(0, 1, 0, 0, pat(8'(k), salt), "R6 read data");
    end
    xfer(1, 1, 0, 0, 8'h00, (op == 4'h1 && eff != 0) ? "R8 status" : "R7 status follows command");
    xfer(1, 1, 1, 0, 8'h00, "R9 message");
    chk(lines() == 6'b0, "R9 bus released", lines(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sel_i = 1'b0; bsy_i = 1'b0; ack_i = 1'b0; bus_din = '0;
    own_id = 3'd5; salt = 8'h5A;
    repeat (3) @(negedge clk);
    chk(lines() == 6'b0 && xfer_idx == 0, "R1 outputs in reset", {lines(), xfer_idx}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(lines() == 6'b0, "R1 outputs after reset", lines(), 0);

    refuse(8'b1000_0001, 1'b0, "R2 other target ignored");
    refuse(8'b1010_0001, 1'b0, "R2 three ID bits ignored");
    refuse(8'b0010_0000, 1'b0, "R2 lone own bit ignored");
    refuse(8'b1010_0000, 1'b1, "R2 busy bus ignored");

    txn(4'h1, 4'd1, 8'd3, 3'd7);
    txn(4'h1, 4'd0, 8'd9, 3'd7);
    txn(4'h1, 4'd2, 8'd0, 3'd0);
    txn(4'h2, 4'd1, 8'd5, 3'd7);
    salt = 8'hC3;
    txn(4'h1, 4'd3, 8'd255, 3'd1);

    select(8'b1010_0000, ok);
    while (!req_o) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(lines() == 6'b0, "R10 reset mid command", lines(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    txn(4'h1, 4'd1, 8'd2, 3'd7);

    for (int t = 0; t < 25; t++) begin
      logic [2:0] ini;
      own_id = 3'($urandom);
      ini = 3'($urandom);
      if (ini == own_id) ini = ini + 3'd1;
      salt = 8'($urandom);
      txn(($urandom % 2) ? 4'h1 : 4'($urandom), 4'($urandom % 4), 8'($urandom % 9), ini);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule